// File: doc/BRIEF.md
# SDRAM Refresh and Power-State Controller

This block sits beside the main SDRAM sequencer. It decides when the memory needs an auto-refresh, and it moves the memory into and out of self refresh and power down. It also enforces the minimum gaps that must surround those commands. A programmable refresh interval is counted in controller ticks. A tick comes every clock in full-rate mode and every second clock in half-rate mode. When an interval expires, a refresh becomes pending. The block then issues a precharge-all, waits out the precharge time, and issues the auto-refresh. After the refresh it holds off every other command for the refresh recovery time.

The main sequencer asks for the memory by raising an access request. The block answers with `grant` once no timing gap is open and no refresh is pending. Grant stays high for as long as the request stays high. A refresh that falls due while grant is high waits until the request drops. Both low-power states drive clock enable low. The self-refresh request wins over the power-down request. An access request wakes either state. An optional mode also wakes power down briefly for each due refresh and then goes back to power down.

Top module: `sdram_refresh_ctl`

## Requirements
- R1: While reset is asserted, `cke` is 1, `grant` is 0 and `cmd` is NOP. Command codes on `cmd`: 0 NOP, 1 precharge-all, 2 auto-refresh, 3 self-refresh entry, 4 self-refresh exit, 5 power-down entry, 6 power-down exit.
- R2: With `full_rate` = 1 and the block idle, auto-refresh commands are exactly N clocks apart, where N is the stored 13-bit refresh rate. The rate resets to 0x80, and a rate write restarts the interval count.
- R3: With `full_rate` = 0, a tick comes every second clock, so idle auto-refresh commands are exactly 2·N clocks apart.
- R4: Writing a rate value below 0x20 stores 2·`t_rfc` + 1 instead. The value 0x20 itself is stored unchanged.
- R5: Every auto-refresh and every self-refresh entry comes exactly `t_rp` + 1 cycles after a precharge-all.
- R6: After an auto-refresh, a waiting access request is granted exactly `t_rfc` + 2 cycles after the auto-refresh cycle.
- R7: With `sr_req` high and no access pending, the block issues precharge-all and then self-refresh entry. Clock enable then stays low and no command is issued for as long as the state lasts, including across refresh intervals.
- R8: When `sr_req` and `pd_req` are both high, self refresh is entered and no power-down entry is issued.
- R9: An access request in self refresh produces a self-refresh exit with `cke` high. Grant rises exactly `t_xs` + 2 cycles after the exit cycle.
- R10: With `pd_req` high, the block issues power-down entry with `cke` low. An access request then produces power-down exit, and grant rises exactly 2 cycles after the exit cycle.
- R11: In power down with `pd_refresh` = 0, a due refresh leaves `cke` low and issues no command. With `pd_refresh` = 1, a due refresh produces power-down exit, precharge-all, auto-refresh and power-down entry, in that order.
- R12: While `grant` is high, only NOP is issued. A refresh that falls due during a grant is started by a precharge-all exactly 2 cycles after the first cycle in which `acc_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| full_rate | input | 1 | 1: one tick per clock; 0: one tick per two clocks |
| rate_wr | input | 1 | One-cycle strobe that loads `rate_val` |
| rate_val | input | 13 | Refresh interval in ticks |
| t_rfc | input | 5 | Refresh recovery time, cycles minus one |
| t_rp | input | 3 | Precharge time, cycles minus one |
| t_xs | input | 5 | Self-refresh exit time, cycles minus one |
| sr_req | input | 1 | Request to hold the memory in self refresh |
| pd_req | input | 1 | Request to hold the memory in power down |
| pd_refresh | input | 1 | Wake from power down for each due refresh |
| acc_req | input | 1 | Main sequencer wants the memory |
| cmd | output | 3 | Command code (see R1) |
| cke | output | 1 | Memory clock enable |
| grant | output | 1 | Memory handed to the main sequencer |

## Verification
The refresh interval is measured between consecutive auto-refresh commands. The runs use random rates in both full-rate and half-rate modes, which separates the tick divider from the interval counter. Directed writes below, at and just under the 0x20 threshold, each with a different `t_rfc`, show whether the substituted value is used. Grant latency is timed after an auto-refresh, a power-down exit and several self-refresh exits with different `t_xs` values (including zero), so each gap can be told apart from the others. Long holds in each low-power state and during a grant show whether due refreshes are correctly suppressed, deferred or serviced.

// File: rtl/rfpm_pkg.sv
package rfpm_pkg;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_PRE_ALL  = 3'd1,
    CMD_AREF     = 3'd2,
    CMD_SR_ENTER = 3'd3,
    CMD_SR_EXIT  = 3'd4,
    CMD_PD_ENTER = 3'd5,
    CMD_PD_EXIT  = 3'd6
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GRANT,
    ST_PRE_REF,
    ST_AREF,
    ST_PRE_SR,
    ST_SR_ENT,
    ST_SELF,
    ST_SR_EXIT,
    ST_PD_ENT,
    ST_PWRDN,
    ST_PD_EXIT
  } state_e;

endpackage

// File: rtl/rfpm_rate_timer.sv
module rfpm_rate_timer #(
  parameter int          RATE_W   = 13,
  parameter int          TRFC_W   = 5,
  parameter int unsigned RATE_RST = 'h80,
  parameter int unsigned RATE_MIN = 'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_rate,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_val,
  input  logic [TRFC_W-1:0] trfc,
  input  logic              ack,
  output logic              pending
);

  localparam logic [RATE_W-1:0] RST_VAL = RATE_W'(RATE_RST);
  localparam logic [RATE_W-1:0] MIN_VAL = RATE_W'(RATE_MIN);
  localparam logic [RATE_W-1:0] ONE     = RATE_W'(1);

  logic [RATE_W-1:0] rate_q, rate_d;
  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic              phase_q, pend_q, pend_d;
  logic              tick, due;

  assign tick = full_rate | phase_q;

  always_comb begin
    rate_d = rate_q;
    cnt_d  = cnt_q;
    due    = 1'b0;
    if (rate_wr) begin
      rate_d = (rate_val < MIN_VAL) ? RATE_W'({trfc, 1'b1}) : rate_val;
      cnt_d  = '0;
    end else if (tick) begin
      if (cnt_q == rate_q - ONE) begin
        cnt_d = '0;
        due   = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
    pend_d = due | (pend_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= RST_VAL;
      cnt_q   <= '0;
      phase_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      rate_q  <= rate_d;
      cnt_q   <= cnt_d;
      phase_q <= ~phase_q;
      pend_q  <= pend_d;
    end
  end

  assign pending = pend_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < rate_q);

  // R2
  due_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    due |=> pend_q);

endmodule

// File: rtl/rfpm_gap_timer.sv
module rfpm_gap_timer #(
  parameter int GAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  output logic             zero
);

  logic [GAP_W-1:0] gap_q, gap_d;

  always_comb begin
    if (load)
      gap_d = load_val;
    else if (gap_q != '0)
      gap_d = gap_q - GAP_W'(1);
    else
      gap_d = gap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else        gap_q <= gap_d;
  end

  assign zero = (gap_q == '0);

  // R5
  gap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q != '0 && !load) |=> gap_q == $past(gap_q) - GAP_W'(1));

endmodule

// File: rtl/rfpm_fsm.sv
module rfpm_fsm
  import rfpm_pkg::*;
#(
  parameter int TRFC_W = 5,
  parameter int TRP_W  = 3,
  parameter int TXS_W  = 5,
  parameter int GAP_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gap_zero,
  input  logic              pending,
  input  logic              acc_req,
  input  logic              sr_req,
  input  logic              pd_req,
  input  logic              pd_refresh,
  input  logic [TRFC_W-1:0] trfc,
  input  logic [TRP_W-1:0]  trp,
  input  logic [TXS_W-1:0]  txs,
  output cmd_e              cmd_o,
  output logic              cke_o,
  output logic              grant_o,
  output logic              ack_o,
  output logic              gap_load,
  output logic [GAP_W-1:0]  gap_val
);

  state_e state_q, state_d, pick;

  // priority: due refresh, then access, then self refresh, then power down
  always_comb begin
    if (pending)      pick = ST_PRE_REF;
    else if (acc_req) pick = ST_GRANT;
    else if (sr_req)  pick = ST_PRE_SR;
    else if (pd_req)  pick = ST_PD_ENT;
    else              pick = ST_IDLE;
  end

  always_comb begin
    state_d  = state_q;
    cmd_o    = CMD_NOP;
    cke_o    = 1'b1;
    ack_o    = 1'b0;
    gap_load = 1'b0;
    gap_val  = '0;
    unique case (state_q)
      ST_IDLE:    if (gap_zero) state_d = pick;
      ST_GRANT:   if (!acc_req) state_d = ST_IDLE;
      ST_PRE_REF: if (gap_zero) begin
        cmd_o = CMD_PRE_ALL; gap_load = 1'b1; gap_val = GAP_W'(trp);
        state_d = ST_AREF;
      end
      ST_AREF:    if (gap_zero) begin
        cmd_o = CMD_AREF; gap_load = 1'b1; gap_val = GAP_W'(trfc);
        ack_o = 1'b1; state_d = ST_IDLE;
      end
      ST_PRE_SR:  if (gap_zero) begin
        cmd_o = CMD_PRE_ALL; gap_load = 1'b1; gap_val = GAP_W'(trp);
        state_d = ST_SR_ENT;
      end
      ST_SR_ENT:  if (gap_zero) begin
        cmd_o = CMD_SR_ENTER; cke_o = 1'b0; ack_o = 1'b1;
        state_d = ST_SELF;
      end
      ST_SELF: begin
        cke_o = 1'b0; ack_o = 1'b1;
        if (acc_req || !sr_req) state_d = ST_SR_EXIT;
      end
      ST_SR_EXIT: begin
        cmd_o = CMD_SR_EXIT; gap_load = 1'b1; gap_val = GAP_W'(txs);
        state_d = ST_IDLE;
      end
      ST_PD_ENT:  if (gap_zero) begin
        cmd_o = CMD_PD_ENTER; cke_o = 1'b0; state_d = ST_PWRDN;
      end
      ST_PWRDN: begin
        cke_o = 1'b0;
        if (acc_req || sr_req || !pd_req || (pd_refresh && pending))
          state_d = ST_PD_EXIT;
      end
      ST_PD_EXIT: begin
        cmd_o = CMD_PD_EXIT; state_d = ST_IDLE;
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign grant_o = (state_q == ST_GRANT);

  // R12
  grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> (cmd_o == CMD_NOP && cke_o));

  // R7
  cke_low_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> (cmd_o inside {CMD_NOP, CMD_SR_ENTER, CMD_PD_ENTER}));

  // R9
  sr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SELF && acc_req) |=> cmd_o == CMD_SR_EXIT);

endmodule

// File: rtl/sdram_refresh_ctl.sv
module sdram_refresh_ctl
  import rfpm_pkg::*;
#(
  parameter int          RATE_W   = 13,
  parameter int          TRFC_W   = 5,
  parameter int          TRP_W    = 3,
  parameter int          TXS_W    = 5,
  parameter int unsigned RATE_RST = 'h80,
  parameter int unsigned RATE_MIN = 'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_rate,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_val,
  input  logic [TRFC_W-1:0] t_rfc,
  input  logic [TRP_W-1:0]  t_rp,
  input  logic [TXS_W-1:0]  t_xs,
  input  logic              sr_req,
  input  logic              pd_req,
  input  logic              pd_refresh,
  input  logic              acc_req,
  output logic [2:0]        cmd,
  output logic              cke,
  output logic              grant
);

  localparam int GAP_A = (TRFC_W > TRP_W) ? TRFC_W : TRP_W;
  localparam int GAP_W = (GAP_A > TXS_W) ? GAP_A : TXS_W;

  logic [1:0]       rs_q;
  logic             srst_n;
  logic             pending, ack, gap_zero, gap_load;
  logic [GAP_W-1:0] gap_val;
  cmd_e             cmd_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  rfpm_rate_timer #(
    .RATE_W(RATE_W), .TRFC_W(TRFC_W), .RATE_RST(RATE_RST), .RATE_MIN(RATE_MIN)
  ) u_rate (
    .clk(clk), .rst_n(srst_n), .full_rate(full_rate), .rate_wr(rate_wr),
    .rate_val(rate_val), .trfc(t_rfc), .ack(ack), .pending(pending)
  );

  rfpm_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(srst_n), .load(gap_load), .load_val(gap_val), .zero(gap_zero)
  );

  rfpm_fsm #(
    .TRFC_W(TRFC_W), .TRP_W(TRP_W), .TXS_W(TXS_W), .GAP_W(GAP_W)
  ) u_fsm (
    .clk(clk), .rst_n(srst_n), .gap_zero(gap_zero), .pending(pending),
    .acc_req(acc_req), .sr_req(sr_req), .pd_req(pd_req), .pd_refresh(pd_refresh),
    .trfc(t_rfc), .trp(t_rp), .txs(t_xs), .cmd_o(cmd_w), .cke_o(cke),
    .grant_o(grant), .ack_o(ack), .gap_load(gap_load), .gap_val(gap_val)
  );

  assign cmd = cmd_w;

endmodule

// File: tb/sim_sdram_refresh_ctl.sv
`timescale 1ns/1ps
module sim_sdram_refresh_ctl;

  localparam logic [2:0] C_NOP = 3'd0, C_PRE = 3'd1, C_AREF = 3'd2,
                         C_SRE = 3'd3, C_SRX = 3'd4, C_PDE = 3'd5, C_PDX = 3'd6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, full_rate, rate_wr, sr_req, pd_req, pd_refresh, acc_req;
  logic [12:0] rate_val;
  int          trfc_v, trp_v, txs_v;
  logic [2:0]  cmd;
  logic        cke, grant;

  sdram_refresh_ctl u0 (
    .clk(clk), .rst_n(rst_n), .full_rate(full_rate), .rate_wr(rate_wr),
    .rate_val(rate_val), .t_rfc(5'(trfc_v)), .t_rp(3'(trp_v)), .t_xs(5'(txs_v)),
    .sr_req(sr_req), .pd_req(pd_req), .pd_refresh(pd_refresh), .acc_req(acc_req),
    .cmd(cmd), .cke(cke), .grant(grant)
  );

  int cyc = 0;
  int n_chk = 0, n_err = 0;
  int last_pre = -1000, pd_enter_cnt = 0;
  bit mon_en = 0;

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_period(int val, int trfc, bit full);
    int r;
    r = (val < 32) ? 2 * trfc + 1 : val;
    return full ? r : 2 * r;
  endfunction

  always @(negedge clk) if (mon_en) begin
    if (cmd == C_PRE) last_pre = cyc;
    if (cmd == C_AREF || cmd == C_SRE)
      chk(cyc - last_pre == trp_v + 1, "R5", "precharge gap", cyc - last_pre, trp_v + 1);
    if (grant && cmd != C_NOP) chk(1'b0, "R12", "command during grant", cmd, 0);
    if (cmd == C_PDE) pd_enter_cnt++;
  end

  task automatic wait_cmd(input logic [2:0] code, input string req, output int at);
    at = -1;
    for (int i = 0; i < 12000; i++) begin
      @(negedge clk);
      if (cmd == code) begin at = cyc; break; end
    end
    if (at < 0) chk(1'b0, req, "command never issued", -1, code);
  endtask

  task automatic wait_grant(output int at);
    at = -1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (grant) begin at = cyc; break; end
    end
  endtask

  task automatic cfg(input int val, input int trfc, input int trp, input bit full);
    @(negedge clk);
    trfc_v = trfc; trp_v = trp; full_rate = full;
    rate_val = 13'(val); rate_wr = 1'b1;
    @(negedge clk);
    rate_wr = 1'b0;
  endtask

  task automatic measure(input string req, input int exp);
    int a0, a1, a2;
    wait_cmd(C_AREF, req, a0);
    wait_cmd(C_AREF, req, a1);
    wait_cmd(C_AREF, req, a2);
    chk(a2 - a1 == exp, req, "refresh period", a2 - a1, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int a, g, g0, p, x, x2, e, s, n0, bad;
    rst_n = 1'b0; full_rate = 1'b1; rate_wr = 1'b0; rate_val = 13'h0;
    sr_req = 1'b0; pd_req = 1'b0; pd_refresh = 1'b0; acc_req = 1'b0;
    trfc_v = 3; trp_v = 1; txs_v = 7;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset outputs
    chk(cke == 1'b1, "R1", "cke in reset", cke, 1);
    chk(cmd == C_NOP, "R1", "cmd in reset", cmd, C_NOP);
    chk(grant == 1'b0, "R1", "grant in reset", grant, 0);
    rst_n = 1'b1; mon_en = 1'b1;

    // R2: reset rate value 0x80
    measure("R2", 128);

    // R2 / R3: random rates in both tick modes
    for (int t = 0; t < 6; t++) begin
      bit full; int val, trfc, trp;
      full = (t == 0) ? 1'b1 : (t == 1) ? 1'b0 : 1'($urandom % 2);
      val  = 64 + int'($urandom % 120);
      trfc = int'($urandom % 16);
      trp  = int'($urandom % 8);
      cfg(val, trfc, trp, full);
      measure(full ? "R2" : "R3", exp_period(val, trfc, full));
    end

    // R4: substitution below threshold, and the threshold itself
    begin
      int v;
      v = int'($urandom % 32);
      cfg(v, 20, 1, 1'b1);
      measure("R4", exp_period(v, 20, 1'b1));
    end
    cfg(31, 12, 2, 1'b0);
    measure("R4", exp_period(31, 12, 1'b0));
    cfg(32, 2, 1, 1'b1);
    measure("R4", 32);

    // R6: grant after auto-refresh recovery
    cfg(100, 9, 3, 1'b1);
    wait_cmd(C_AREF, "R6", a);
    acc_req = 1'b1;
    wait_grant(g);
    chk(g == a + 9 + 2, "R6", "grant after refresh", g - a, 11);

    // R12: refresh deferred during a long grant
    bad = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (!grant) bad++;
    end
    chk(bad == 0, "R12", "grant dropped while requested", bad, 0);
    acc_req = 1'b0; g0 = cyc;
    wait_cmd(C_PRE, "R12", p);
    chk(p == g0 + 2, "R12", "deferred precharge", p - g0, 2);
    wait_cmd(C_AREF, "R12", a);

    // R10: power down entry
    pd_req = 1'b1;
    wait_cmd(C_PDE, "R10", x);
    chk(cke == 1'b0, "R10", "cke at power-down entry", cke, 0);

    // R11: due refresh ignored without wake mode
    bad = 0;
    for (int i = 0; i < 250; i++) begin
      @(negedge clk);
      if (cke != 1'b0 || cmd != C_NOP) bad++;
    end
    chk(bad == 0, "R11", "activity in power down", bad, 0);

    // R11: wake-to-refresh sequence
    pd_refresh = 1'b1;
    wait_cmd(C_PDX, "R11", x);
    wait_cmd(C_PRE, "R11", p);
    wait_cmd(C_AREF, "R11", a);
    wait_cmd(C_PDE, "R11", x2);
    chk(x > 0 && p > x && a > p && x2 > a, "R11", "wake refresh order", x2, a + 1);
    chk(cke == 1'b0, "R11", "cke after re-entry", cke, 0);

    // R10: access wakes power down
    acc_req = 1'b1;
    wait_cmd(C_PDX, "R10", x);
    wait_grant(g);
    chk(g == x + 2, "R10", "grant after power-down exit", g - x, 2);
    acc_req = 1'b0; pd_req = 1'b0; pd_refresh = 1'b0;

    // R7 / R8: both low-power requests set
    sr_req = 1'b1; pd_req = 1'b1;
    n0 = pd_enter_cnt;
    wait_cmd(C_SRE, "R7", s);
    chk(cke == 1'b0, "R7", "cke at self-refresh entry", cke, 0);
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (cke != 1'b0 || cmd != C_NOP) bad++;
    end
    chk(bad == 0, "R7", "activity in self refresh", bad, 0);

    // R9: wake with several exit times
    for (int k = 0; k < 3; k++) begin
      int t;
      t = (k == 0) ? 12 : (k == 1) ? 0 : int'($urandom % 32);
      cfg(4000, 9, 3, 1'b1);
      txs_v = t;
      acc_req = 1'b1;
      wait_cmd(C_SRX, "R9", e);
      chk(cke == 1'b1, "R9", "cke at self-refresh exit", cke, 1);
      wait_grant(g);
      chk(g == e + t + 2, "R9", "grant after self-refresh exit", g - e, t + 2);
      acc_req = 1'b0;
      wait_cmd(C_SRE, "R7", s);
    end
    chk(pd_enter_cnt == n0, "R8", "power-down entries while self refresh wanted",
        pd_enter_cnt - n0, 0);
    sr_req = 1'b0; pd_req = 1'b0;
    repeat (20) @(negedge clk);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule